// File: doc/BRIEF.md
# Bridge Leg PWM Generator with Dead-Time, Blanked Overcurrent and Sample Strobes

This block drives one half-bridge leg of a motor power stage. A free-running phase counter compares a duty command against a period setting to form a PWM level. That level becomes two complementary gate signals, one for the high-side switch and one for the low-side switch. After every change of level, a programmable dead-time keeps both switches off before the incoming side is turned on.

Each period the block produces two strobes. The first is an ADC sample strobe, placed in the middle of the longer of the two intervals (conducting or non-conducting), away from the switching edges. It is dropped, and a skip indication raised for the period, when that interval is too short to hold a clean window after blanking. The second is a control-update strobe in the first cycle of every period.

A fast overcurrent comparator input is ignored for a programmable blanking time after each level change. Overcurrent, overtemperature and undervoltage each latch their own flag. Any active trip or latched flag forces both gates off in the same cycle. A flag clears only on an explicit clear while its own input is inactive.

Top module: `bridge_leg_pwm`

## Requirements
- R1: `gate_hi_o` and `gate_lo_o` are never 1 in the same cycle.
- R2: The gate level follows the registered PWM level, which lags the raw level by one cycle. When that registered level changes, both gates are off for exactly the number of cycles the dead setting held when the change was detected. The new side then turns on. A level change during the gap restarts the gap.
- R3: The period, duty, dead and blank settings are taken only in the last cycle of a period. Period values below 2 are used as 2, and a duty above the period is used as the period. The phase counter runs 0 to P-1, and the raw PWM level is 1 while phase < duty.
- R4: With duty D and period P, `samp_o` pulses once per period, at phase D/2 when D >= P-D, otherwise at phase D+(P-D)/2, using integer division.
- R5: When max(D, P-D) < blank + MIN_WIN, `samp_skip_o` is 1 for that period and `samp_o` stays 0.
- R6: `upd_o` is 1 exactly in the phase-0 cycle of every running period.
- R7: `oc_cmp_i` is ignored for the first blank-setting cycles that follow each change of the registered PWM level.
- R8: An unblanked `oc_cmp_i`, `ot_flt_i` or `uv_flt_i` sets its own flag (`flt_oc_o`, `flt_ot_o`, `flt_uv_o`) in the next cycle.
- R9: In the same cycle as an unblanked overcurrent, overtemperature or undervoltage input, and in every cycle while any flag is set, both gates are 0.
- R10: A set flag stays set until a cycle in which `clr_i` is 1 and that flag's own input is 0. It is 0 from the next cycle.
- R11: During reset and until the first period has been loaded, both gates and all strobes and flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_i | input | CW | Duty command in clock cycles |
| period_i | input | CW | PWM period in clock cycles |
| dead_i | input | DW | Dead-time in clock cycles |
| blank_i | input | BW | Overcurrent blanking time in clock cycles |
| oc_cmp_i | input | 1 | Fast overcurrent comparator output |
| ot_flt_i | input | 1 | Overtemperature fault input |
| uv_flt_i | input | 1 | Undervoltage fault input |
| clr_i | input | 1 | Fault flag clear request |
| gate_hi_o | output | 1 | High-side gate drive |
| gate_lo_o | output | 1 | Low-side gate drive |
| samp_o | output | 1 | Current-sample strobe |
| samp_skip_o | output | 1 | Sample suppressed for this period |
| upd_o | output | 1 | Control-update strobe |
| flt_oc_o | output | 1 | Latched overcurrent flag |
| flt_ot_o | output | 1 | Latched overtemperature flag |
| flt_uv_o | output | 1 | Latched undervoltage flag |

## Verification
The bench changes the duty in the middle of a period. A design that reloads it at once would cut a pulse short, and the gates would depart from the model within that period. It covers zero duty, duty above the period, a period of 1, zero dead-time and a window too short for sampling. A wrong clamp or a reversed comparison against the blanking would show as a misplaced or missing sample strobe. Overcurrent pulses are placed one cycle into the blanking time and again after it ends. Clears are issued both while the fault input is still high and after it has dropped. A design with an off-by-one blanking count, or with a clear that is not gated by the input, would show a flag or gate mismatch in that cycle.

// File: rtl/blp_pkg.sv
package blp_pkg;

  // Smallest usable period is two cycles.
  function automatic int clamp_period(int p);
    return (p < 2) ? 2 : p;
  endfunction

  // Duty may not exceed the period.
  function automatic int clamp_duty(int d, int p);
    return (d > p) ? p : d;
  endfunction

  // Length of the longer of the conducting and non-conducting intervals.
  function automatic int longer_span(int d, int p);
    return (d >= p - d) ? d : p - d;
  endfunction

  // Phase at the middle of the longer interval.
  function automatic int centre_pos(int d, int p);
    return (d >= p - d) ? d / 2 : d + (p - d) / 2;
  endfunction

  // True when the longer interval cannot hold a clean window after blanking.
  function automatic logic window_short(int d, int p, int blank, int minw);
    return longer_span(d, p) < blank + minw;
  endfunction

endpackage

// File: rtl/blp_timebase.sv
module blp_timebase
  import blp_pkg::*;
#(
  parameter int CW      = 10,
  parameter int DW      = 6,
  parameter int BW      = 6,
  parameter int MIN_WIN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] duty_i,
  input  logic [CW-1:0] period_i,
  input  logic [DW-1:0] dead_i,
  input  logic [BW-1:0] blank_i,
  output logic          run_o,
  output logic          raw_o,
  output logic [DW-1:0] dead_o,
  output logic [BW-1:0] blank_o,
  output logic          samp_o,
  output logic          skip_o,
  output logic          upd_o
);
  logic [CW-1:0] cnt_q, per_q, duty_q;
  logic [DW-1:0] dead_q;
  logic [BW-1:0] blank_q;
  logic          wrap_w;
  logic [CW-1:0] pos_w;
  int            per_new;

  assign wrap_w  = (per_q == '0) || (cnt_q == per_q - CW'(1));
  assign per_new = clamp_period(int'(period_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      per_q   <= '0;
      duty_q  <= '0;
      dead_q  <= '0;
      blank_q <= '0;
    end else if (wrap_w) begin
      cnt_q   <= '0;
      per_q   <= CW'(per_new);
      duty_q  <= CW'(clamp_duty(int'(duty_i), per_new));
      dead_q  <= dead_i;
      blank_q <= blank_i;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign pos_w   = CW'(centre_pos(int'(duty_q), int'(per_q)));
  assign skip_o  = window_short(int'(duty_q), int'(per_q), int'(blank_q), MIN_WIN);
  assign run_o   = (per_q != '0);
  assign raw_o   = (cnt_q < duty_q);
  assign samp_o  = (cnt_q == pos_w) && !skip_o;
  assign upd_o   = run_o && (cnt_q == '0);
  assign dead_o  = dead_q;
  assign blank_o = blank_q;

  // R3: settings move only at a period start
  a_r3_settings_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q != '0 && cnt_q != '0) |-> ($stable(duty_q) && $stable(per_q) && $stable(dead_q)));

  // R6: one update strobe per period, never back to back
  a_r6_upd_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> !upd_o);

endmodule

// File: rtl/blp_deadband.sv
module blp_deadband #(
  parameter int DW = 6,
  parameter int BW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raw_i,
  input  logic [DW-1:0] dead_i,
  input  logic [BW-1:0] blank_i,
  input  logic          oc_cmp_i,
  input  logic          en_i,
  output logic          gate_hi_o,
  output logic          gate_lo_o,
  output logic          oc_valid_o,
  output logic          edge_o
);
  logic          lvl_q;
  logic [DW-1:0] dcnt_q;
  logic [BW-1:0] bcnt_q;
  logic          settled_w;

  assign edge_o = (raw_i != lvl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      dcnt_q <= '0;
      bcnt_q <= '0;
    end else begin
      lvl_q <= raw_i;
      if (edge_o) begin
        dcnt_q <= dead_i;
        bcnt_q <= blank_i;
      end else begin
        if (dcnt_q != '0) dcnt_q <= dcnt_q - DW'(1);
        if (bcnt_q != '0) bcnt_q <= bcnt_q - BW'(1);
      end
    end
  end

  assign settled_w  = (dcnt_q == '0);
  assign gate_hi_o  = en_i && lvl_q && settled_w;
  assign gate_lo_o  = en_i && !lvl_q && settled_w;
  assign oc_valid_o = oc_cmp_i && (bcnt_q == '0);

  // R1: complementary outputs never overlap
  a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi_o && gate_lo_o));

  // R2: a level change with a non-zero dead setting leaves both gates off next cycle
  a_r2_gap_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_o && dead_i != '0) |=> (!gate_hi_o && !gate_lo_o));

  // R7: a level change with a non-zero blank setting masks the comparator next cycle
  a_r7_blank_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_o && blank_i != '0) |=> !oc_valid_o);

endmodule

// File: rtl/blp_fault.sv
module blp_fault #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] active_i,
  input  logic          clr_i,
  output logic [NF-1:0] flag_o
);
  for (genvar k = 0; k < NF; k++) begin : g_flag
    logic f_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     f_q <= 1'b0;
      else if (set_i[k])              f_q <= 1'b1;
      else if (clr_i && !active_i[k]) f_q <= 1'b0;
    end

    assign flag_o[k] = f_q;

    // R8: a qualified fault input latches next cycle
    a_r8_set_next: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[k] |=> flag_o[k]);

    // R10: without a qualified clear the flag holds
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o[k] && !(clr_i && !active_i[k])) |=> flag_o[k]);
  end

endmodule

// File: rtl/bridge_leg_pwm.sv
module bridge_leg_pwm #(
  parameter int CW      = 10,
  parameter int DW      = 6,
  parameter int BW      = 6,
  parameter int MIN_WIN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] duty_i,
  input  logic [CW-1:0] period_i,
  input  logic [DW-1:0] dead_i,
  input  logic [BW-1:0] blank_i,
  input  logic          oc_cmp_i,
  input  logic          ot_flt_i,
  input  logic          uv_flt_i,
  input  logic          clr_i,
  output logic          gate_hi_o,
  output logic          gate_lo_o,
  output logic          samp_o,
  output logic          samp_skip_o,
  output logic          upd_o,
  output logic          flt_oc_o,
  output logic          flt_ot_o,
  output logic          flt_uv_o
);
  localparam int NF = 3;

  logic          run_w, raw_w, edge_w, oc_valid_w, trip_w, flag_any_w, en_w;
  logic [DW-1:0] dead_w;
  logic [BW-1:0] blank_w;
  logic [NF-1:0] fset_w, fact_w, flag_w;

  blp_timebase #(.CW(CW), .DW(DW), .BW(BW), .MIN_WIN(MIN_WIN)) u_tb (
    .clk(clk), .rst_n(rst_n), .duty_i(duty_i), .period_i(period_i),
    .dead_i(dead_i), .blank_i(blank_i), .run_o(run_w), .raw_o(raw_w),
    .dead_o(dead_w), .blank_o(blank_w), .samp_o(samp_o),
    .skip_o(samp_skip_o), .upd_o(upd_o)
  );

  blp_deadband #(.DW(DW), .BW(BW)) u_db (
    .clk(clk), .rst_n(rst_n), .raw_i(raw_w), .dead_i(dead_w),
    .blank_i(blank_w), .oc_cmp_i(oc_cmp_i), .en_i(en_w),
    .gate_hi_o(gate_hi_o), .gate_lo_o(gate_lo_o),
    .oc_valid_o(oc_valid_w), .edge_o(edge_w)
  );

  // flag order: 0 overcurrent, 1 overtemperature, 2 undervoltage
  assign fset_w = {uv_flt_i, ot_flt_i, oc_valid_w};
  assign fact_w = {uv_flt_i, ot_flt_i, oc_cmp_i};

  blp_fault #(.NF(NF)) u_flt (
    .clk(clk), .rst_n(rst_n), .set_i(fset_w), .active_i(fact_w),
    .clr_i(clr_i), .flag_o(flag_w)
  );

  assign trip_w     = oc_valid_w || ot_flt_i || uv_flt_i;
  assign flag_any_w = |flag_w;
  assign en_w       = run_w && !trip_w && !flag_any_w;

  assign flt_oc_o = flag_w[0];
  assign flt_ot_o = flag_w[1];
  assign flt_uv_o = flag_w[2];

  // R9: any trip or latched flag keeps both switches off
  a_r9_off_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_w || flag_any_w) |-> (!gate_hi_o && !gate_lo_o));

  // R5: a suppressed window never emits a sample
  a_r5_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    samp_skip_o |-> !samp_o);

endmodule

// File: tb/sim_bridge_leg_pwm.sv
module sim_bridge_leg_pwm;
  localparam int CW = 10, DW = 6, BW = 6, MINW = 4;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] duty = '0, period = '0;
  logic [DW-1:0] dead = '0;
  logic [BW-1:0] blank = '0;
  logic oc = 0, ot = 0, uv = 0, clr = 0;
  logic hi, lo, samp, skip, upd, f_oc, f_ot, f_uv;

  always #2 clk = ~clk;

  bridge_leg_pwm #(.CW(CW), .DW(DW), .BW(BW), .MIN_WIN(MINW)) u0 (
    .clk(clk), .rst_n(rst_n), .duty_i(duty), .period_i(period),
    .dead_i(dead), .blank_i(blank), .oc_cmp_i(oc), .ot_flt_i(ot),
    .uv_flt_i(uv), .clr_i(clr), .gate_hi_o(hi), .gate_lo_o(lo),
    .samp_o(samp), .samp_skip_o(skip), .upd_o(upd),
    .flt_oc_o(f_oc), .flt_ot_o(f_ot), .flt_uv_o(f_uv)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // reference model state
  int m_cnt = 0, m_per = 0, m_duty = 0, m_dead = 0, m_blank = 0;
  int m_since = 0, m_dl = 0, m_bl = 0;
  bit m_lvl = 0;
  bit m_fl[3] = '{0, 0, 0};

  task automatic chk(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // behavioural model, advanced on each rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_cnt = 0; m_per = 0; m_duty = 0; m_dead = 0; m_blank = 0;
      m_since = 0; m_dl = 0; m_bl = 0; m_lvl = 0;
      m_fl = '{0, 0, 0};
    end else begin
      bit r, ocv;
      int p;
      r   = (m_cnt < m_duty);
      ocv = oc && (m_since >= m_bl);
      if (ocv) m_fl[0] = 1; else if (clr && !oc) m_fl[0] = 0;
      if (ot)  m_fl[1] = 1; else if (clr && !ot) m_fl[1] = 0;
      if (uv)  m_fl[2] = 1; else if (clr && !uv) m_fl[2] = 0;
      if (r != m_lvl) begin
        m_lvl = r; m_since = 0; m_dl = m_dead; m_bl = m_blank;
      end else if (m_since < 100000) begin
        m_since++;
      end
      if (m_per == 0 || m_cnt == m_per - 1) begin
        p = (int'(period) < 2) ? 2 : int'(period);
        m_cnt = 0; m_per = p;
        m_duty = (int'(duty) > p) ? p : int'(duty);
        m_dead = int'(dead); m_blank = int'(blank);
      end else begin
        m_cnt++;
      end
    end
  end

  // comparison, away from the rising edge and after input updates
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      bit run, ocv, en, eskip, esamp;
      int big, pos;
      run = (m_per != 0);
      ocv = oc && (m_since >= m_bl);
      en  = run && !(ocv || ot || uv) && !(m_fl[0] || m_fl[1] || m_fl[2]);
      big = (m_duty > m_per - m_duty) ? m_duty : m_per - m_duty;
      eskip = (big < m_blank + MINW);
      pos = (2 * m_duty >= m_per) ? m_duty / 2 : m_duty + (m_per - m_duty) / 2;
      esamp = !eskip && (m_cnt == pos);
      chk("R1 overlap", hi && lo, 1'b0);
      chk("R2/R9 gate_hi", hi, en && m_lvl && (m_since >= m_dl));
      chk("R2/R9 gate_lo", lo, en && !m_lvl && (m_since >= m_dl));
      chk("R4 samp", samp, esamp);
      chk("R5 samp_skip", skip, eskip);
      chk("R6 upd", upd, run && (m_cnt == 0));
      chk("R7 R8 R10 flt_oc", f_oc, m_fl[0]);
      chk("R8 R10 flt_ot", f_ot, m_fl[1]);
      chk("R8 R10 flt_uv", f_uv, m_fl[2]);
    end
  end

  always @(posedge clk) begin
    if (cyc > WATCHDOG && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
      summary();
      $finish;
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    period = 20; duty = 8; dead = 2; blank = 3;
    step(3);
    #1;
    // R11: quiet during reset
    chk("R11 reset gate_hi", hi, 1'b0);
    chk("R11 reset gate_lo", lo, 1'b0);
    chk("R11 reset upd", upd, 1'b0);
    chk("R11 reset samp", samp, 1'b0);
    chk("R11 reset flags", f_oc | f_ot | f_uv, 1'b0);
    @(negedge clk);
    rst_n = 1;
    step(70);                              // R4: off interval longer
    duty = 15; step(60);                   // R4: on interval longer
    step(7); duty = 3; step(50);           // R3: mid-period change
    duty = 0; step(45);
    duty = 30; step(45);                   // R3: duty clamp
    period = 1; duty = 1; step(20);        // R3: period clamp
    period = 10; duty = 5; blank = 4; step(30);  // R5: short window
    period = 12; duty = 4; dead = 0; blank = 0; step(40);
    period = 40; duty = 20; dead = 3; blank = 5; step(90);
    // R7: pulse inside blanking is ignored
    while (!(m_since == 1 && m_bl == 5)) @(negedge clk);
    oc = 1; step(1); oc = 0; step(5);
    // R8/R9: pulse after blanking trips
    while (m_since != 8) @(negedge clk);
    oc = 1; step(1); oc = 0; step(5);
    // R10: clear while input high has no effect
    oc = 1; clr = 1; step(1); clr = 0; oc = 0; step(3);
    clr = 1; step(1); clr = 0; step(10);
    ot = 1; step(1); ot = 0; step(3);
    clr = 1; step(1); clr = 0; step(5);
    uv = 1; step(2); clr = 1; step(1); clr = 0; step(1); uv = 0; step(3);
    clr = 1; step(1); clr = 0; step(50);
    done = 1;
    summary();
    $finish;
  end
endmodule